// File: doc/BRIEF.md
# Bitwise Ternary/Binary LUT Unit

This execution unit computes a bitwise logic function of its 64-bit operands. For each bit lane, the function is given as a small truth table. There are two operations. The ternary operation uses three inputs and looks up each lane in an 8-bit immediate. Its inputs are the old destination value, operand A and operand B, so the destination is read and then rewritten. The binary operation uses two inputs, operand A and operand B. Its 4-entry table is a nibble taken at run time from a third operand, and a select bit chooses between the lowest nibble and the one above it.

The unit has one output register. When the input-valid strobe is high, the register captures the result, and a result-valid strobe follows one cycle later. The record bit asks for a 3-bit sign summary of the result, returned with it. A dynamic three-input function can be built in three steps. Two binary operations, one on each nibble, produce two partial results. A ternary operation with the merge constant 0xD8 then combines them.

Top module: `bitlut_unit`

## Requirements
- R1: After reset, out_valid, out_res and out_flags are all zero, and they stay zero until an input is accepted.
- R2: With in_op = 0 (ternary), each result bit i takes in_imm[k]. Here k = 4*in_x[i] + 2*in_a[i] + in_b[i], so index 0 selects the least significant immediate bit and index 7 the most significant.
- R3: With in_op = 1 (binary) and in_nsel = 0, each result bit i takes T[k]. Here T = in_x[3:0] and k = 2*in_a[i] + in_b[i].
- R4: With in_op = 1 and in_nsel = 1, the table T is in_x[7:4]. All other bits of in_x and all of in_imm have no effect on the result.
- R5: A ternary operation with in_imm = 8'hD8 yields (in_x & ~in_b) | (in_a & in_b). An in_imm of 8'h00 yields all zeros, and 8'hFF yields all ones.
- R6: When in_rec = 1, out_flags is {neg, pos, zero} in bits [2], [1] and [0], with exactly one bit set. neg means the result bit 63 is 1, zero means the result is all zeros, and pos covers every other result. When in_rec = 0, out_flags is 3'b000.
- R7: out_valid is high in exactly the cycle that follows an accepted input. Without in_valid, out_res and out_flags hold their previous values.
- R8: In the ternary operation, in_nsel has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Accept the operands this cycle |
| in_op | input | 1 | 0 = ternary immediate LUT, 1 = binary register-nibble LUT |
| in_x | input | 64 | Old destination (ternary) or table source (binary) |
| in_a | input | 64 | Operand A |
| in_b | input | 64 | Operand B |
| in_imm | input | 8 | Ternary truth table |
| in_nsel | input | 1 | Binary table nibble select: 0 = bits 3:0, 1 = bits 7:4 |
| in_rec | input | 1 | Request the sign summary |
| out_valid | output | 1 | Result register loaded on the previous edge |
| out_res | output | 64 | Registered result |
| out_flags | output | 3 | Registered {neg, pos, zero} summary |

## Verification
The first stimulus is a structured sweep. It places the operands so that each bit position i sees index i mod 8 (or i mod 4 for the binary operation). With this placement, every byte of the result must repeat the table exactly, which shows up any swapped index bit or reversed table order. Random operands with random tables check that lanes are independent. The constants 00, FF and D8 check the edge functions and the merge function. Binary operations are also run with random upper bits in in_x, a random in_imm and both nibble selections, to confirm that only the selected nibble matters. The ternary operation is run with in_nsel toggled for the same purpose.

// File: rtl/bitlut_pkg.sv
`timescale 1ns/1ps
package bitlut_pkg;

   typedef enum logic {
      LUT_OP_TERN = 1'b0,
      LUT_OP_BIN  = 1'b1
   } lut_op_e;

   localparam int SIGN_FLAG_W = 3;

   typedef struct packed {
      logic neg;
      logic pos;
      logic zero;
   } sign_flags_t;

   // Table ordering variants selected by generate
   localparam int ORDER_WEIGHT = 0;   // index k addresses table bit of weight k
   localparam int ORDER_MSB    = 1;   // index 0 addresses the table's top bit

endpackage

// File: rtl/bitlut_tern.sv
`timescale 1ns/1ps
module bitlut_tern
   import bitlut_pkg::*;
#(
   parameter int W     = 64,
   parameter int ORDER = ORDER_WEIGHT
) (
   input  logic [W-1:0] x,
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic [7:0]   tbl,
   output logic [W-1:0] y
);

   localparam int IDX_W = 3;

   for (genvar i = 0; i < W; i++) begin : g_lane
      logic [IDX_W-1:0] idx;
      assign idx = {x[i], a[i], b[i]};
      if (ORDER == ORDER_WEIGHT) begin : g_wt
         assign y[i] = tbl[idx];
      end else begin : g_msb
         assign y[i] = tbl[3'(7) - idx];
      end
   end

endmodule

// File: rtl/bitlut_bin.sv
`timescale 1ns/1ps
module bitlut_bin
   import bitlut_pkg::*;
#(
   parameter int W     = 64,
   parameter int ORDER = ORDER_WEIGHT
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic [3:0]   nib,
   output logic [W-1:0] y
);

   localparam int IDX_W = 2;

   for (genvar i = 0; i < W; i++) begin : g_lane
      logic [IDX_W-1:0] idx;
      assign idx = {a[i], b[i]};
      if (ORDER == ORDER_WEIGHT) begin : g_wt
         assign y[i] = nib[idx];
      end else begin : g_msb
         assign y[i] = nib[2'(3) - idx];
      end
   end

endmodule

// File: rtl/bitlut_sign.sv
`timescale 1ns/1ps
module bitlut_sign
   import bitlut_pkg::*;
#(
   parameter int W = 64
) (
   input  logic [W-1:0]  val,
   input  logic          rec,
   output sign_flags_t   flags
);

   logic is_neg;
   logic is_zero;

   assign is_neg  = val[W-1];
   assign is_zero = ~|val;

   always_comb begin
      flags = '0;
      if (rec) begin
         flags.neg  = is_neg;
         flags.zero = is_zero;
         flags.pos  = ~is_neg & ~is_zero;
      end
   end

endmodule

// File: rtl/bitlut_unit.sv
`timescale 1ns/1ps
module bitlut_unit
   import bitlut_pkg::*;
#(
   parameter int DATA_W      = 64,
   parameter int TABLE_ORDER = ORDER_WEIGHT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              in_op,
   input  logic [DATA_W-1:0] in_x,
   input  logic [DATA_W-1:0] in_a,
   input  logic [DATA_W-1:0] in_b,
   input  logic [7:0]        in_imm,
   input  logic              in_nsel,
   input  logic              in_rec,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_res,
   output logic [2:0]        out_flags
);

   localparam int TERN_TBL_W = 8;
   localparam int NIB_W      = TERN_TBL_W / 2;

   // Elaboration-time parameter checks
   if (DATA_W < 2 * NIB_W) begin : g_chk_w
      $error("bitlut_unit: DATA_W must hold two table nibbles");
   end
   if (TABLE_ORDER != ORDER_WEIGHT && TABLE_ORDER != ORDER_MSB) begin : g_chk_ord
      $error("bitlut_unit: unknown TABLE_ORDER");
   end

   lut_op_e           op;
   logic [NIB_W-1:0]  table_nib;
   logic [DATA_W-1:0] tern_y;
   logic [DATA_W-1:0] bin_y;
   logic [DATA_W-1:0] res_d;
   sign_flags_t       flags_d;
   logic [DATA_W-1:0] res_q;
   sign_flags_t       flags_q;
   logic              valid_q;

   assign op        = lut_op_e'(in_op);
   assign table_nib = in_nsel ? in_x[2*NIB_W-1:NIB_W] : in_x[NIB_W-1:0];

   bitlut_tern #(.W(DATA_W), .ORDER(TABLE_ORDER)) u_tern (
      .x   (in_x),
      .a   (in_a),
      .b   (in_b),
      .tbl (in_imm),
      .y   (tern_y)
   );

   bitlut_bin #(.W(DATA_W), .ORDER(TABLE_ORDER)) u_bin (
      .a   (in_a),
      .b   (in_b),
      .nib (table_nib),
      .y   (bin_y)
   );

   assign res_d = (op == LUT_OP_TERN) ? tern_y : bin_y;

   bitlut_sign #(.W(DATA_W)) u_sign (
      .val   (res_d),
      .rec   (in_rec),
      .flags (flags_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         res_q   <= '0;
         flags_q <= '0;
      end else begin
         valid_q <= in_valid;
         if (in_valid) begin
            res_q   <= res_d;
            flags_q <= flags_d;
         end
      end
   end

   assign out_valid = valid_q;
   assign out_res   = res_q;
   assign out_flags = flags_q;

   // Handshake timing
   assert_valid_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   assert_valid_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(out_res) && $stable(out_flags)));

   // Sign summary
   assert_flags_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_rec) |=> ($countones(out_flags) == 1));
   assert_flags_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_rec) |=> (out_flags == 3'b000));

   // Constant tables
   assert_const_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op == LUT_OP_TERN && in_imm == 8'h00) |=> (out_res == '0));
   assert_const_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op == LUT_OP_TERN && in_imm == 8'hFF) |=> (out_res == '1));

endmodule

// File: tb/sim_bitlut_unit.sv
`timescale 1ns/1ps
module sim_bitlut_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_op = 1'b0;
   logic [63:0] in_x = '0, in_a = '0, in_b = '0;
   logic [7:0]  in_imm = '0;
   logic        in_nsel = 1'b0;
   logic        in_rec = 1'b0;
   logic        out_valid;
   logic [63:0] out_res;
   logic [2:0]  out_flags;

   int n_tests = 0;
   int n_fail  = 0;

   always #2.5 clk = ~clk;

   bitlut_unit u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
      .in_x(in_x), .in_a(in_a), .in_b(in_b), .in_imm(in_imm),
      .in_nsel(in_nsel), .in_rec(in_rec),
      .out_valid(out_valid), .out_res(out_res), .out_flags(out_flags)
   );

   // ---------------- reference model ----------------
   function automatic logic [63:0] ref_tern(logic [63:0] x, logic [63:0] a,
                                            logic [63:0] b, logic [7:0] t);
      logic [63:0] r;
      for (int i = 0; i < 64; i++) begin
         int k;
         k = 4 * int'(x[i]) + 2 * int'(a[i]) + int'(b[i]);
         r[i] = t[k];
      end
      return r;
   endfunction

   function automatic logic [63:0] ref_bin(logic [63:0] x, logic [63:0] a,
                                           logic [63:0] b, logic sel);
      logic [63:0] r;
      logic [3:0]  t;
      t = sel ? x[7:4] : x[3:0];
      for (int i = 0; i < 64; i++) begin
         int k;
         k = 2 * int'(a[i]) + int'(b[i]);
         r[i] = t[k];
      end
      return r;
   endfunction

   function automatic logic [2:0] ref_flags(logic [63:0] r, logic rec);
      if (!rec) return 3'b000;
      if (r[63]) return 3'b100;
      if (r == 64'd0) return 3'b001;
      return 3'b010;
   endfunction

   logic        m_valid = 1'b0;
   logic [63:0] m_res = '0;
   logic [2:0]  m_flags = '0;
   string       m_tag = "R7";
   string       cur_tag = "R2";
   logic [63:0] nxt;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_valid <= 1'b0;
         m_res   <= '0;
         m_flags <= '0;
         m_tag   <= "R1";
      end else begin
         m_valid <= in_valid;
         if (in_valid) begin
            nxt = (in_op == 1'b0) ? ref_tern(in_x, in_a, in_b, in_imm)
                                  : ref_bin(in_x, in_a, in_b, in_nsel);
            m_res   <= nxt;
            m_flags <= ref_flags(nxt, in_rec);
            m_tag   <= cur_tag;
         end
      end
   end

   // ---------------- comparison, every clock ----------------
   always @(negedge clk) begin
      if (!rst_n) begin
         n_tests++;
         if (out_valid !== 1'b0 || out_res !== 64'd0 || out_flags !== 3'b000) begin
            n_fail++;
            $display("FAIL R1 reset state: valid=%b res=%h flags=%b expected 0/0/0",
                     out_valid, out_res, out_flags);
         end
      end else begin
         n_tests++;
         if (out_valid !== m_valid) begin
            n_fail++;
            $display("FAIL R7 out_valid=%b expected %b", out_valid, m_valid);
         end
         n_tests++;
         if (out_res !== m_res) begin
            n_fail++;
            $display("FAIL %s out_res=%h expected %h", m_tag, out_res, m_res);
         end
         n_tests++;
         if (out_flags !== m_flags) begin
            n_fail++;
            $display("FAIL R6 out_flags=%b expected %b", out_flags, m_flags);
         end
      end
   end

   // ---------------- stimulus ----------------
   task automatic send(logic op, logic [63:0] x, logic [63:0] a, logic [63:0] b,
                       logic [7:0] imm, logic sel, logic rec, string tag);
      @(negedge clk); #1;
      in_valid = 1'b1; in_op = op; in_x = x; in_a = a; in_b = b;
      in_imm = imm; in_nsel = sel; in_rec = rec; cur_tag = tag;
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); #1;
         in_valid = 1'b0;
         in_x = {$urandom(), $urandom()};
         in_a = {$urandom(), $urandom()};
         in_imm = 8'($urandom());
         cur_tag = "R7";
      end
   endtask

   function automatic logic [63:0] r64();
      return {$urandom(), $urandom()};
   endfunction

   // index sweep patterns: lane i sees index i mod 8 / i mod 4
   localparam logic [63:0] SW_X = 64'hF0F0_F0F0_F0F0_F0F0;
   localparam logic [63:0] SW_A = 64'hCCCC_CCCC_CCCC_CCCC;
   localparam logic [63:0] SW_B = 64'hAAAA_AAAA_AAAA_AAAA;

   initial begin
      // R1: reset with junk on the inputs
      in_valid = 1'b1; in_x = '1; in_a = '1; in_b = '1; in_imm = 8'hFF;
      repeat (4) @(negedge clk);
      #1; in_valid = 1'b0;
      rst_n = 1'b1;
      idle(2);

      // R2: sweep, result bytes mirror the immediate
      send(1'b0, SW_X, SW_A, SW_B, 8'hB4, 1'b0, 1'b0, "R2");
      send(1'b0, SW_X, SW_A, SW_B, 8'h01, 1'b0, 1'b1, "R2");
      send(1'b0, SW_X, SW_A, SW_B, 8'h80, 1'b0, 1'b1, "R2");
      idle(1);
      for (int n = 0; n < 40; n++)
         send(1'b0, r64(), r64(), r64(), 8'($urandom()), 1'b0, 1'($urandom()), "R2");
      idle(2);

      // R3: binary, low nibble, sweep and random
      send(1'b1, 64'h0000_0000_0000_0006, SW_A, SW_B, 8'h00, 1'b0, 1'b1, "R3");
      send(1'b1, 64'h0000_0000_0000_0009, SW_A, SW_B, 8'h00, 1'b0, 1'b0, "R3");
      for (int n = 0; n < 30; n++)
         send(1'b1, r64(), r64(), r64(), 8'($urandom()), 1'b0, 1'($urandom()), "R3");
      idle(2);

      // R4: binary, upper nibble, garbage elsewhere in x and in imm
      send(1'b1, 64'hFFFF_FFFF_FFFF_FF3C, SW_A, SW_B, 8'hFF, 1'b1, 1'b1, "R4");
      for (int n = 0; n < 30; n++)
         send(1'b1, r64(), r64(), r64(), 8'($urandom()), 1'b1, 1'($urandom()), "R4");
      idle(1);

      // R5: constants and the merge function
      send(1'b0, r64(), r64(), r64(), 8'h00, 1'b0, 1'b1, "R5");
      send(1'b0, r64(), r64(), r64(), 8'hFF, 1'b0, 1'b1, "R5");
      for (int n = 0; n < 10; n++) begin
         logic [63:0] x, a, b;
         x = r64(); a = r64(); b = r64();
         send(1'b0, x, a, b, 8'hD8, 1'b0, 1'b0, "R5");
         @(negedge clk); #1; in_valid = 1'b0; cur_tag = "R7";
         @(posedge clk); #1;
         n_tests++;
         if (out_res !== ((x & ~b) | (a & b))) begin
            n_fail++;
            $display("FAIL R5 merge res=%h expected %h", out_res, (x & ~b) | (a & b));
         end
      end

      // R6: sign classes
      send(1'b0, '0, '0, '0, 8'h01, 1'b0, 1'b1, "R6");             // all ones -> neg
      send(1'b0, '0, '0, '0, 8'h02, 1'b0, 1'b1, "R6");             // zero
      send(1'b0, '0, '0, 64'h1, 8'h02, 1'b0, 1'b1, "R6");          // positive
      send(1'b0, '0, '0, 64'h1, 8'h02, 1'b0, 1'b0, "R6");          // no record
      idle(3);

      // R8: nsel toggled on ternary
      for (int n = 0; n < 20; n++)
         send(1'b0, r64(), r64(), r64(), 8'($urandom()), 1'b1, 1'($urandom()), "R8");
      send(1'b0, SW_X, SW_A, SW_B, 8'h5A, 1'b1, 1'b1, "R8");

      // R7: sparse valid pattern
      for (int n = 0; n < 20; n++) begin
         send(1'($urandom()), r64(), r64(), r64(), 8'($urandom()), 1'($urandom()),
              1'($urandom()), "R7");
         idle(int'($urandom_range(0, 3)));
      end
      idle(3);

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #1000000;
      n_fail++;
      n_tests++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule